// File: doc/BRIEF.md
# Sensor Packet Framer with Fletcher Checksum

This block turns a sensor message into a framed byte stream for a serial transmitter. A requester gives a message type code and a payload byte count on a request handshake. The payload bytes then arrive on a second handshake. The framer sends two fixed marker bytes first. After them come the type code, the count, each payload byte in order, and two check bytes. The check bytes hold a running two-sum Fletcher checksum that is built while the bytes go out, so the payload is never stored.

The output is a registered valid/ready stream, meant to feed a UART transmitter running at 115200 baud. Payload intake is stalled while the frame header is going out and while the check bytes are going out. The framer accepts only three type codes. A request with any other code is consumed and answered with a one-cycle error pulse, and no byte is sent for it. When the sink is always ready and payload is always offered, consecutive frames leave with no idle cycle between them.

Top module: `sensor_framer`

## Requirements
- R1: After reset, out_valid, bad_id and pay_ready are 0 and req_ready is 1.
- R2: Every frame begins with the byte 0x81 followed by the byte 0xA1.
- R3: The third byte of a frame is the requested type code and the fourth byte is the requested payload count.
- R4: Exactly req_len payload bytes follow the count byte, in the order they were accepted on the payload handshake. When req_len is 0, no payload byte is taken and the check bytes follow the count byte directly.
- R5: The last two bytes are sum1 and then sum2. Both start at 0 for each frame. For every byte from the type code to the last payload byte, in order, sum1 = (sum1 + byte) mod 256 and then sum2 = (sum2 + sum1) mod 256.
- R6: Once out_valid is 1 while out_ready is 0, out_valid stays 1 and out_data stays unchanged on the next cycle.
- R7: pay_ready is 0 while the marker, type and count bytes of an accepted frame are waiting to go out, and it is also 0 during the check bytes.
- R8: With default parameters the accepted type codes are 0x01, 0x0C and 0x14. A request with any other code is accepted on the request handshake. bad_id is then 1 for the single cycle after that accepting edge, and no output byte is produced for the request.
- R9: With out_ready held at 1 and payload always offered, a frame with N payload bytes takes N+6 consecutive output transfers. A following frame starts on the very next transfer cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Frame request offered |
| req_ready | output | 1 | Framer can take a request |
| req_id | input | 8 | Message type code of the request |
| req_len | input | 8 | Payload byte count of the request |
| pay_valid | input | 1 | Payload byte offered |
| pay_ready | output | 1 | Framer takes the payload byte |
| pay_data | input | 8 | Payload byte |
| out_valid | output | 1 | Output byte valid (registered) |
| out_ready | input | 1 | Sink takes the output byte |
| out_data | output | 8 | Framed output byte (registered) |
| bad_id | output | 1 | One-cycle pulse for a rejected type code |

## Verification
The first marker byte is valid right after the clock edge that accepts a request. Each later byte becomes valid one edge after the previous byte is taken, or one edge after its payload byte is accepted. bad_id rises one edge after a rejected request is accepted. The bench changes inputs just after the rising edge and samples at the falling edge, which is when the handshake values for the next rising edge are settled. The scoreboard pops one expected byte per sampled transfer. Fixed-latency results are read at the falling edge that directly follows the edge producing them: the error pulse, the pay_ready stall during a held header, and the gap-free run length over two back-to-back frames.

// File: rtl/sensor_framer_pkg.sv
package sensor_framer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC2,
    ST_ID,
    ST_LEN,
    ST_PAY,
    ST_CK1,
    ST_CK2
  } seq_state_t;

  typedef enum logic [2:0] {
    SEL_SYNC1,
    SEL_SYNC2,
    SEL_ID,
    SEL_LEN,
    SEL_PAY,
    SEL_CK1,
    SEL_CK2
  } byte_sel_t;

endpackage

// File: rtl/fmr_id_check.sv
module fmr_id_check #(
  parameter int DW      = 8,
  parameter int NUM_IDS = 3,
  parameter logic [NUM_IDS*DW-1:0] ID_LIST = {8'h14, 8'h0C, 8'h01}
) (
  input  logic [DW-1:0] id,
  output logic          id_ok
);

  logic [NUM_IDS-1:0] hit;

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_cmp
    assign hit[g] = (id == ID_LIST[g*DW +: DW]);
  end

  assign id_ok = |hit;

endmodule

// File: rtl/fmr_fletcher.sv
module fmr_fletcher #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] sum1,
  output logic [DW-1:0] sum2
);

  logic [DW-1:0] s1_next;

  assign s1_next = sum1 + din;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sum1 <= '0;
      sum2 <= '0;
    end else if (en) begin
      sum1 <= s1_next;
      sum2 <= sum2 + s1_next;
    end
  end

  // R5: a new frame starts both sums from zero
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (rst)
    clear |=> (sum1 == '0) && (sum2 == '0));

endmodule

// File: rtl/fmr_seq.sv
module fmr_seq
  import sensor_framer_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          req_valid,
  input  logic          id_ok,
  input  logic [LW-1:0] req_len,
  input  logic          pay_valid,
  output logic          req_ready,
  output logic          pay_ready,
  output logic          accept,
  output logic          reject,
  output logic          load,
  output byte_sel_t     sel,
  output logic          ck_clear,
  output logic          ck_en,
  output logic [LW-1:0] len_o
);

  seq_state_t    state, state_n;
  logic [LW-1:0] len_q;
  logic [LW-1:0] cnt_q;
  logic          last_pay;

  assign req_ready = (state == ST_IDLE) && adv;
  assign accept    = req_valid && req_ready;
  assign reject    = accept && !id_ok;
  assign last_pay  = (cnt_q == len_q - 1'b1);
  assign len_o     = len_q;

  always_comb begin
    state_n   = state;
    load      = 1'b0;
    sel       = SEL_SYNC1;
    ck_clear  = 1'b0;
    ck_en     = 1'b0;
    pay_ready = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (accept && id_ok) begin
          load     = 1'b1;
          sel      = SEL_SYNC1;
          ck_clear = 1'b1;
          state_n  = ST_SYNC2;
        end
      end
      ST_SYNC2: begin
        if (adv) begin
          load    = 1'b1;
          sel     = SEL_SYNC2;
          state_n = ST_ID;
        end
      end
      ST_ID: begin
        if (adv) begin
          load    = 1'b1;
          sel     = SEL_ID;
          ck_en   = 1'b1;
          state_n = ST_LEN;
        end
      end
      ST_LEN: begin
        if (adv) begin
          load    = 1'b1;
          sel     = SEL_LEN;
          ck_en   = 1'b1;
          state_n = (len_q == '0) ? ST_CK1 : ST_PAY;
        end
      end
      ST_PAY: begin
        pay_ready = adv;
        if (adv && pay_valid) begin
          load  = 1'b1;
          sel   = SEL_PAY;
          ck_en = 1'b1;
          if (last_pay) state_n = ST_CK1;
        end
      end
      ST_CK1: begin
        if (adv) begin
          load    = 1'b1;
          sel     = SEL_CK1;
          state_n = ST_CK2;
        end
      end
      ST_CK2: begin
        if (adv) begin
          load    = 1'b1;
          sel     = SEL_CK2;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      len_q <= '0;
      cnt_q <= '0;
    end else begin
      state <= state_n;
      if (accept) begin
        len_q <= req_len;
        cnt_q <= '0;
      end else if (load && (sel == SEL_PAY)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R4: the payload counter never reaches the requested count while payload is open
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PAY) |-> (cnt_q < len_q));

  // R4: a zero count skips the payload phase
  p_zero_skip_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LEN) && adv && (len_q == '0) |=> (state == ST_CK1));

endmodule

// File: rtl/sensor_framer.sv
module sensor_framer
  import sensor_framer_pkg::*;
#(
  parameter int DW      = 8,
  parameter int LW      = 8,
  parameter int NUM_IDS = 3,
  parameter logic [NUM_IDS*DW-1:0] ID_LIST = {8'h14, 8'h0C, 8'h01},
  parameter logic [DW-1:0] SYNC_A = 8'h81,
  parameter logic [DW-1:0] SYNC_B = 8'hA1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [DW-1:0] req_id,
  input  logic [LW-1:0] req_len,
  input  logic          pay_valid,
  output logic          pay_ready,
  input  logic [DW-1:0] pay_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          bad_id
);

  localparam int PADW = (DW > LW) ? DW - LW : 0;

  logic          adv;
  logic          id_ok;
  logic          accept;
  logic          reject;
  logic          load;
  byte_sel_t     sel;
  logic          ck_clear;
  logic          ck_en;
  logic [LW-1:0] len_q;
  logic [DW-1:0] id_q;
  logic [DW-1:0] sum1;
  logic [DW-1:0] sum2;
  logic [DW-1:0] byte_n;
  logic          valid_q;
  logic [DW-1:0] data_q;
  logic          bad_q;

  assign adv = !valid_q || out_ready;

  fmr_id_check #(.DW(DW), .NUM_IDS(NUM_IDS), .ID_LIST(ID_LIST)) i_id_check (
    .id    (req_id),
    .id_ok (id_ok)
  );

  fmr_seq #(.LW(LW)) i_seq (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .req_valid (req_valid),
    .id_ok     (id_ok),
    .req_len   (req_len),
    .pay_valid (pay_valid),
    .req_ready (req_ready),
    .pay_ready (pay_ready),
    .accept    (accept),
    .reject    (reject),
    .load      (load),
    .sel       (sel),
    .ck_clear  (ck_clear),
    .ck_en     (ck_en),
    .len_o     (len_q)
  );

  always_comb begin
    unique case (sel)
      SEL_SYNC1: byte_n = SYNC_A;
      SEL_SYNC2: byte_n = SYNC_B;
      SEL_ID:    byte_n = id_q;
      SEL_LEN:   byte_n = DW'({{PADW{1'b0}}, len_q});
      SEL_PAY:   byte_n = pay_data;
      SEL_CK1:   byte_n = sum1;
      SEL_CK2:   byte_n = sum2;
      default:   byte_n = '0;
    endcase
  end

  fmr_fletcher #(.DW(DW)) i_fletcher (
    .clk   (clk),
    .rst   (rst),
    .clear (ck_clear),
    .en    (ck_en),
    .din   (byte_n),
    .sum1  (sum1),
    .sum2  (sum2)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      id_q    <= '0;
      bad_q   <= 1'b0;
    end else begin
      bad_q <= reject;
      if (accept) id_q <= req_id;
      if (load) begin
        valid_q <= 1'b1;
        data_q  <= byte_n;
      end else if (adv) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign bad_id    = bad_q;

  // R6: a byte that is not taken stays on the output unchanged
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R7: payload intake is closed right after a frame is accepted
  p_pay_wait_r7: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !pay_ready);

  // R8: a rejected code raises the error pulse and loads no byte
  p_reject_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !id_ok |=> bad_id && $stable(out_data));

  // R2: an accepted frame puts the first marker byte on the output
  p_first_sync_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && id_ok |=> out_valid && (out_data == SYNC_A));

endmodule

// File: tb/test_sensor_framer.sv
module test_sensor_framer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] req_id = 8'h00;
  logic [7:0] req_len = 8'h00;
  logic       pay_valid = 1'b0;
  logic       pay_ready;
  logic [7:0] pay_data = 8'h00;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       bad_id;

  int total = 0;
  int bad = 0;
  int ready_mode = 0;
  int err_seen = 0;
  int cur_run = 0;
  int max_run = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  sensor_framer i_sensor_framer (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id), .req_len(req_len),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .bad_id(bad_id)
  );

  task automatic check(input string req, input logic ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic allowed(input logic [7:0] id);
    return (id == 8'h01) || (id == 8'h0C) || (id == 8'h14);
  endfunction

  // sink ready pattern, changed just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      case (ready_mode)
        0: out_ready = 1'b1;
        1: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          out_ready = lfsr[0] | lfsr[5];
        end
        default: out_ready = 1'b0;
      endcase
    end
  end

  // monitor and scoreboard, sampling at the falling edge
  initial begin
    logic       pv;
    logic       pr;
    logic [7:0] pd;
    pv = 1'b0; pr = 1'b0; pd = 8'h00;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (pv && !pr)
          check("R6", out_valid && (out_data == pd), {out_valid, out_data}, {1'b1, pd});
        if (bad_id) err_seen++;
        if (out_valid && out_ready) begin
          cur_run++;
          if (cur_run > max_run) max_run = cur_run;
          if (exp_q.size() == 0) begin
            check("R8", 1'b0, out_data, 0);
          end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, out_data == e, out_data, e);
          end
        end else begin
          cur_run = 0;
        end
        pv = out_valid; pr = out_ready; pd = out_data;
      end
    end
  end

  // called just after a rising edge; returns just after a rising edge
  task automatic send_pkt(input logic [7:0] id, input logic [7:0] len,
                          input logic [7:0] base, input logic gap);
    logic got;
    logic [7:0] s1, s2, b;
    if (allowed(id)) begin
      s1 = 8'h00; s2 = 8'h00;
      exp_q.push_back(8'h81); tag_q.push_back("R2");
      exp_q.push_back(8'hA1); tag_q.push_back("R2");
      exp_q.push_back(id);    tag_q.push_back("R3");
      exp_q.push_back(len);   tag_q.push_back("R3");
      s1 = s1 + id;  s2 = s2 + s1;
      s1 = s1 + len; s2 = s2 + s1;
      for (int i = 0; i < len; i++) begin
        b = base + 8'(i * 37);
        exp_q.push_back(b); tag_q.push_back("R4");
        s1 = s1 + b; s2 = s2 + s1;
      end
      exp_q.push_back(s1); tag_q.push_back("R5");
      exp_q.push_back(s2); tag_q.push_back("R5");
    end
    req_valid = 1'b1; req_id = id; req_len = len;
    do begin
      @(negedge clk); got = req_ready;
      @(posedge clk); #1;
    end while (!got);
    req_valid = 1'b0;
    if (allowed(id)) begin
      for (int i = 0; i < len; i++) begin
        if (gap && (i % 3 == 1)) begin
          pay_valid = 1'b0;
          @(posedge clk); #1;
        end
        pay_valid = 1'b1;
        pay_data = base + 8'(i * 37);
        do begin
          @(negedge clk); got = pay_ready;
          @(posedge clk); #1;
        end while (!got);
        pay_valid = 1'b0;
      end
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) begin
      @(posedge clk); #1;
    end
    repeat (3) begin
      @(posedge clk); #1;
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", out_valid == 1'b0, out_valid, 0);
    check("R1", bad_id == 1'b0, bad_id, 0);
    check("R1", pay_ready == 1'b0, pay_ready, 0);
    check("R1", req_ready == 1'b1, req_ready, 1);
    @(posedge clk); #1;

    // R2 R3 R4 R5: basic frame, sink always ready
    ready_mode = 0;
    send_pkt(8'h01, 8'd5, 8'h10, 1'b0);
    drain();

    // R4: zero payload count
    send_pkt(8'h14, 8'd0, 8'h00, 1'b0);
    drain();

    // R6: random sink stalls with payload gaps
    ready_mode = 1;
    send_pkt(8'h0C, 8'd12, 8'hF0, 1'b1);
    drain();

    // R7: header held by a stalled sink keeps payload closed
    ready_mode = 2;
    fork
      send_pkt(8'h0C, 8'd3, 8'h55, 1'b0);
      begin
        repeat (6) begin
          @(negedge clk);
          check("R7", pay_ready == 1'b0, pay_ready, 0);
        end
        ready_mode = 0;
      end
    join
    drain();

    // R8: rejected codes
    send_pkt(8'h55, 8'd2, 8'h00, 1'b0);
    @(negedge clk);
    check("R8", bad_id == 1'b1, bad_id, 1);
    @(posedge clk); #1;
    send_pkt(8'h00, 8'd4, 8'h00, 1'b0);
    @(negedge clk);
    check("R8", bad_id == 1'b1, bad_id, 1);
    repeat (6) @(negedge clk);
    check("R8", out_valid == 1'b0, out_valid, 0);
    @(posedge clk); #1;

    // R9: back-to-back frames with no idle transfer cycle
    ready_mode = 0;
    cur_run = 0; max_run = 0;
    send_pkt(8'h01, 8'd3, 8'h21, 1'b0);
    send_pkt(8'h14, 8'd0, 8'h00, 1'b0);
    drain();
    check("R9", max_run == 15, max_run, 15);

    // R5: long frame so the sums wrap many times
    ready_mode = 1;
    send_pkt(8'h0C, 8'd255, 8'hC3, 1'b0);
    drain();

    check("R4", exp_q.size() == 0, exp_q.size(), 0);
    check("R8", err_seen == 2, err_seen, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule